// File: doc/BRIEF.md
# Instruction Fetch Patch Remapper

This unit sits between a processor's fetch path and its two memories. Every read request carries a flag telling whether it is an instruction fetch. A fetch below the SRAM boundary is compared against a set of word comparators. When the unit is switched on and an enabled comparator in remap mode matches the fetched word, the read goes to the SRAM patch table instead of flash. Comparator n always supplies the word at table base + 4·n. Any other read keeps its own address. Reads below the boundary go to flash and reads at or above it go to SRAM. Data reads never see a patch.

Software programs the unit through a small word-wide register bus. The registers are a control word with a keyed enable and a read-only comparator count, a table base register aligned to 32 bytes and fixed into the SRAM region, and one register per comparator. Both memory ports have one cycle of read latency, so each request is answered one cycle after it is presented.

Top module: `fpatch_remap`

## Requirements
- R1: After reset the control word reads with bit 0 clear and bits [7:4] equal to the number of implemented comparators. The table base reads 0x20000000, every comparator register reads zero, and every fetch is served from flash.
- R2: A write to the control word (offset 0x000) changes the enable in bit 0 only when bit 1 of the same write is 1. Bit 1 always reads as zero.
- R3: The table base register (offset 0x004) stores bits [28:5] of the written value. Its bits [31:29] read as 3'b001 and its bits [4:0] read as zero.
- R4: Comparator n sits at offset 0x008 + 4·n. Bit 0 is its enable, bits [28:2] hold the word address and bits [31:30] hold the mode; bits 29 and 1 read as zero. Offsets of comparators that are not implemented read zero and ignore writes.
- R5: A fetch matches when the unit is enabled and an enabled mode-0 comparator's address equals the fetch address bits [28:2]. Address bits [1:0] play no part in the match. A matching fetch is read from SRAM at base + 4·n, and rsp_patched is 1 with that response.
- R6: A data read (req_ifetch = 0) is never redirected, even at a patched address.
- R7: A fetch at or above 0x20000000 is never patched. It is read from SRAM at its own address, even when its bits [28:2] equal a comparator address.
- R8: While the control enable is clear, no fetch is patched, whatever the comparators hold.
- R9: When several enabled comparators match, the lowest-numbered one selects the table entry.
- R10: A comparator whose mode field is not zero never redirects a fetch.
- R11: Each request is answered exactly one cycle later. Only one memory port is requested per cycle, and rsp_data comes from the port that was requested.
- R12: A fetch below 0x20000000 that is not patched is read from flash at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when 1, read when 0 |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Read request from the core |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Request byte address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_data | output | 32 | Response word |
| rsp_patched | output | 1 | Response came from the patch table |
| fl_req | output | 1 | Flash read request |
| fl_addr | output | 32 | Flash read address |
| fl_rdata | input | 32 | Flash read data, one cycle after fl_req |
| sr_req | output | 1 | SRAM read request |
| sr_addr | output | 32 | SRAM read address |
| sr_rdata | input | 32 | SRAM read data, one cycle after sr_req |

## Verification
The bench builds the block with NUM_CMP = 6 and REG_AW = 8. The count field therefore reads 6, which differs from the default of 8. The offsets of comparators 6 and 7 fall inside the address range but are not implemented, so the bench can check that they read zero and that a write to them does not create a patch. Six comparators also leave room to program duplicate entries for the priority check and a nonzero-mode entry, alongside the three consecutive patch words at addr, addr+4 and addr+8.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned TAG_W    = 27;          // address bits [28:2]
   localparam int unsigned MAX_CMP  = 8;
   localparam int unsigned CMP_BASE_IDX = 2;       // word index of comparator 0
   localparam logic [2:0]  SRAM_TOP = 3'b001;      // region bits [31:29] of SRAM

   typedef struct packed {
      logic [1:0]       mode;
      logic [TAG_W-1:0] tag;
      logic             en;
   } cmp_t;

   function automatic logic [WORD_W-1:0] cmp_pack(input cmp_t c);
      return {c.mode, 1'b0, c.tag, 1'b0, c.en};
   endfunction

   function automatic cmp_t cmp_unpack(input logic [WORD_W-1:0] w);
      cmp_t c;
      c.mode = w[31:30];
      c.tag  = w[28:2];
      c.en   = w[0];
      return c;
   endfunction

endpackage

// File: rtl/fpatch_regs.sv
module fpatch_regs
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 8,
   parameter int unsigned REG_AW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              glb_en,
   output logic [WORD_W-1:0] remap_base,
   output cmp_t [NUM_CMP-1:0] cmp_o
);

   localparam int unsigned RIW = REG_AW - 2;
   localparam logic [3:0]  CNT = 4'(NUM_CMP);

   logic [RIW-1:0] widx;
   logic           wr_stb;
   logic           glb_q;
   logic [23:0]    base_q;

   assign widx   = reg_addr[REG_AW-1:2];
   assign wr_stb = reg_en && reg_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_q  <= 1'b0;
         base_q <= '0;
      end else if (wr_stb) begin
         if (widx == RIW'(0) && reg_wdata[1]) glb_q <= reg_wdata[0];
         if (widx == RIW'(1)) base_q <= reg_wdata[28:5];
      end
   end

   assign glb_en     = glb_q;
   assign remap_base = {SRAM_TOP, base_q, 5'b0};

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      cmp_t q;
      logic sel;
      assign sel = wr_stb && (widx == RIW'(i + CMP_BASE_IDX));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (sel) q <= cmp_unpack(reg_wdata);
      end
      assign cmp_o[i] = q;
   end

   always_comb begin
      reg_rdata = '0;
      if (widx == RIW'(0)) reg_rdata = {24'b0, CNT, 3'b0, glb_q};
      if (widx == RIW'(1)) reg_rdata = remap_base;
      for (int i = 0; i < NUM_CMP; i++) begin
         if (widx == RIW'(i + CMP_BASE_IDX)) reg_rdata = cmp_pack(cmp_o[i]);
      end
   end

   // R2: the enable holds unless the key bit accompanies the write
   p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && widx == RIW'(0) && !reg_wdata[1]) |=> $stable(glb_en));

   // R3: the table base never leaves the SRAM region
   p_base_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
      remap_base[31:29] == SRAM_TOP && remap_base[4:0] == 5'b0);

endmodule

// File: rtl/fpatch_match.sv
module fpatch_match
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_ifetch,
   input  logic [WORD_W-1:0]  req_addr,
   input  logic               glb_en,
   input  cmp_t [NUM_CMP-1:0] cmps,
   output logic               hit,
   output logic [IDX_W-1:0]   hit_idx
);

   logic               in_code;
   logic               qualify;
   logic [NUM_CMP-1:0] raw;

   assign in_code = (req_addr[31:29] == 3'b000);
   assign qualify = req_valid && req_ifetch && glb_en && in_code;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      assign raw[i] = qualify && cmps[i].en && (cmps[i].mode == 2'b00)
                      && (cmps[i].tag == req_addr[28:2]);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = NUM_CMP - 1; i >= 0; i--) begin
         if (raw[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |raw;

   // R6: data reads never produce a patch hit
   p_fetch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ifetch) |-> !hit);

   // R7: nothing at or above the SRAM boundary is patched
   p_code_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[31:29] != 3'b000) |-> !hit);

   // R8: a disabled unit produces no hit
   p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !hit);

   // R9: no lower-numbered comparator matched when an entry is chosen
   p_lowest_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (raw & ((NUM_CMP'(1) << hit_idx) - NUM_CMP'(1))) == '0);

endmodule

// File: rtl/fpatch_route.sv
module fpatch_route
   import fpatch_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_addr,
   input  logic              hit,
   input  logic [IDX_W-1:0]  hit_idx,
   input  logic [WORD_W-1:0] remap_base,
   output logic              fl_req,
   output logic [WORD_W-1:0] fl_addr,
   output logic              sr_req,
   output logic [WORD_W-1:0] sr_addr,
   input  logic [WORD_W-1:0] fl_rdata,
   input  logic [WORD_W-1:0] sr_rdata,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic              rsp_patched
);

   logic              high;
   logic [WORD_W-1:0] slot_addr;
   logic              vld_q, from_sr_q, patch_q;

   assign high      = (req_addr[31:29] != 3'b000);
   assign slot_addr = remap_base | WORD_W'({hit_idx, 2'b00});

   assign fl_req  = req_valid && !hit && !high;
   assign fl_addr = req_addr;
   assign sr_req  = req_valid && (hit || high);
   assign sr_addr = hit ? slot_addr : req_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         from_sr_q <= 1'b0;
         patch_q   <= 1'b0;
      end else begin
         vld_q     <= req_valid;
         from_sr_q <= sr_req;
         patch_q   <= hit;
      end
   end

   assign rsp_valid   = vld_q;
   assign rsp_patched = patch_q;
   assign rsp_data    = from_sr_q ? sr_rdata : fl_rdata;

   // R11: one response per request, exactly one cycle later
   p_resp_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_resp_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R11: never two memory ports at once
   p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_req && sr_req));
   // R5: a patched read targets the table inside the SRAM region
   p_slot_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (sr_req && sr_addr[31:29] == 3'b001));

endmodule

// File: rtl/fpatch_remap.sv
module fpatch_remap
   import fpatch_pkg::*;
#(
   parameter int unsigned NUM_CMP = 8,
   parameter int unsigned REG_AW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              req_valid,
   input  logic              req_ifetch,
   input  logic [31:0]       req_addr,
   output logic              rsp_valid,
   output logic [31:0]       rsp_data,
   output logic              rsp_patched,
   output logic              fl_req,
   output logic [31:0]       fl_addr,
   input  logic [31:0]       fl_rdata,
   output logic              sr_req,
   output logic [31:0]       sr_addr,
   input  logic [31:0]       sr_rdata
);

   localparam int unsigned IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

   if (NUM_CMP < 1 || NUM_CMP > MAX_CMP) begin : g_bad_cnt
      $error("NUM_CMP must lie in 1..8");
   end
   if ((NUM_CMP + CMP_BASE_IDX) * 4 > (1 << REG_AW)) begin : g_bad_aw
      $error("REG_AW too small for the comparator registers");
   end

   logic               glb_en;
   logic [31:0]        remap_base;
   cmp_t [NUM_CMP-1:0] cmps;
   logic               hit;
   logic [IDX_W-1:0]   hit_idx;

   fpatch_regs #(.NUM_CMP(NUM_CMP), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .glb_en(glb_en), .remap_base(remap_base), .cmp_o(cmps)
   );

   fpatch_match #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_match (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ifetch(req_ifetch),
      .req_addr(req_addr), .glb_en(glb_en), .cmps(cmps),
      .hit(hit), .hit_idx(hit_idx)
   );

   fpatch_route #(.IDX_W(IDX_W)) u_route (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .hit(hit), .hit_idx(hit_idx), .remap_base(remap_base),
      .fl_req(fl_req), .fl_addr(fl_addr), .sr_req(sr_req), .sr_addr(sr_addr),
      .fl_rdata(fl_rdata), .sr_rdata(sr_rdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_patched(rsp_patched)
   );

   // R12: an unpatched fetch in the code region reads flash at its own address
   p_flash_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_patched_next() && req_addr[31:29] == 3'b000)
      |-> (fl_req && fl_addr == req_addr));

   function automatic logic rsp_patched_next();
      return hit;
   endfunction

endmodule

// File: tb/sim_fpatch_remap.sv
`timescale 1ns/1ps
module sim_fpatch_remap;

   localparam int unsigned NCMP = 6;
   localparam int unsigned RAW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_en = 1'b0, reg_we = 1'b0;
   logic [RAW-1:0] reg_addr = '0;
   logic [31:0]    reg_wdata = '0, reg_rdata;
   logic           req_valid = 1'b0, req_ifetch = 1'b0;
   logic [31:0]    req_addr = '0;
   logic           rsp_valid, rsp_patched;
   logic [31:0]    rsp_data;
   logic           fl_req, sr_req;
   logic [31:0]    fl_addr, sr_addr;
   logic [31:0]    fl_rdata = '0, sr_rdata = '0;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] q_data[$];
   logic        q_pat[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   fpatch_remap #(.NUM_CMP(NCMP), .REG_AW(RAW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ifetch(req_ifetch), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_patched(rsp_patched),
      .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
      .sr_req(sr_req), .sr_addr(sr_addr), .sr_rdata(sr_rdata)
   );

   function automatic logic [31:0] fw(input logic [31:0] a);
      return a ^ 32'hA5C3_0000;
   endfunction
   function automatic logic [31:0] sw(input logic [31:0] a);
      return a ^ 32'h3C5A_0000;
   endfunction

   // one-cycle memory models
   always @(posedge clk) begin
      if (fl_req) fl_rdata <= fw(fl_addr);
      if (sr_req) sr_rdata <= sw(sr_addr);
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop expected items as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q_data.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 unexpected response actual=%h expected=none", rsp_data);
         end else begin
            logic [31:0] d;
            logic        p;
            string       t;
            d = q_data.pop_front();
            p = q_pat.pop_front();
            t = q_tag.pop_front();
            check({t, " data"}, rsp_data, d);
            check({t, " patched"}, {31'b0, rsp_patched}, {31'b0, p});
         end
      end
   end

   // driver: present one request and record its expected response
   task automatic fetch(input logic [31:0] a, input logic f, input logic [31:0] d,
                        input logic p, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_ifetch = f; req_addr = a;
      q_data.push_back(d); q_pat.push_back(p); q_tag.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_ifetch = 1'b0;
   endtask

   task automatic wr(input logic [RAW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd(input logic [RAW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
      #1 check(tag, reg_rdata, exp);
      @(negedge clk);
      reg_en = 1'b0;
   endtask

   localparam logic [31:0] TB = 32'h2003_8000;

   initial begin : watchdog
      #(200000 * 5);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(8'h00, 32'h0000_0060, "R1 ctrl");
      rd(8'h04, 32'h2000_0000, "R1 base");
      rd(8'h08, 32'h0, "R1 cmp0");
      rd(8'h1C, 32'h0, "R1 cmp5");
      fetch(32'h0000_1000, 1'b1, fw(32'h0000_1000), 1'b0, "R1 fetch");
      idle();

      // R2: keyed enable
      wr(8'h00, 32'h1);
      rd(8'h00, 32'h60, "R2 no key");
      wr(8'h00, 32'h3);
      rd(8'h00, 32'h61, "R2 keyed");

      // R3: base alignment and region
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 32'h3FFF_FFE0, "R3 ones");
      wr(8'h04, TB);
      rd(8'h04, TB, "R3 base");

      // R4: comparator field layout
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'hDFFF_FFFD, "R4 fields");
      wr(8'h08, 32'h0000_8215);
      wr(8'h0C, 32'h0000_8219);
      wr(8'h10, 32'h0000_821D);
      rd(8'h08, 32'h0000_8215, "R4 cmp0");

      // R5 / R11: consecutive patch words, back to back
      fetch(32'h0000_8214, 1'b1, sw(TB),        1'b1, "R5 slot0");
      fetch(32'h0000_8216, 1'b1, sw(TB),        1'b1, "R5 low bits");
      fetch(32'h0000_8218, 1'b1, sw(TB + 4),    1'b1, "R5 slot1");
      fetch(32'h0000_821C, 1'b1, sw(TB + 8),    1'b1, "R5 slot2");
      fetch(32'h0000_8220, 1'b1, fw(32'h8220),  1'b0, "R12 neighbour");
      // R6: data read at patched address
      fetch(32'h0000_8214, 1'b0, fw(32'h8214),  1'b0, "R6 data");
      // R7: alias above the boundary
      fetch(32'h2000_8214, 1'b1, sw(32'h2000_8214), 1'b0, "R7 high alias");
      idle();

      // R9: duplicate comparators, lowest wins
      wr(8'h14, 32'h0000_8215);               // comparator 3
      fetch(32'h0000_8214, 1'b1, sw(TB),      1'b1, "R9 lowest");
      idle();
      wr(8'h08, 32'h0000_8214);               // comparator 0 disabled
      fetch(32'h0000_8214, 1'b1, sw(TB + 12), 1'b1, "R9 next");
      idle();

      // R10: nonzero mode does not redirect
      wr(8'h18, 32'h4000_9001);               // comparator 4, mode 1
      rd(8'h18, 32'h4000_9001, "R10 readback");
      fetch(32'h0000_9000, 1'b1, fw(32'h9000), 1'b0, "R10 mode");
      idle();

      // R4: unimplemented comparator offsets
      wr(8'h20, 32'h0000_A001);
      wr(8'h24, 32'h0000_A001);
      rd(8'h20, 32'h0, "R4 slot6");
      rd(8'h24, 32'h0, "R4 slot7");
      fetch(32'h0000_A000, 1'b1, fw(32'hA000), 1'b0, "R4 slot6 inert");
      idle();

      // R8: global disable
      wr(8'h00, 32'h2);
      rd(8'h00, 32'h60, "R8 ctrl");
      fetch(32'h0000_8218, 1'b1, fw(32'h8218), 1'b0, "R8 off");
      fetch(32'h0000_8214, 1'b1, fw(32'h8214), 1'b0, "R8 off slot3");
      idle();

      repeat (3) @(negedge clk);
      check("R11 drained", 32'(q_data.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule